// File: doc/BRIEF.md
# Four-to-One Serializer with Selectable Capture Edge

This block turns a stream of narrow parallel words into a serial bit stream running at WORD_W times the word rate (four by default). The serial clock is the block's own fast clock. Words arrive with a parallel input clock that is generated in step with the serial clock. That input clock can run at the word rate, with capture on its rising edge only. It can also run at half the word rate, with capture on both of its edges. Each captured word sits in a holding register. The shifter reloads from that register on the serial cycle right after the last bit of the current word has gone out, so consecutive words leave with no gap. If no new word has been captured by then, the last word is sent again.

The block also produces a word-rate output clock by dividing the serial clock by WORD_W. It drives a copy of the serial clock that can be switched off, with an output-enable flag. A secondary loopback output carries either the serial data or the word-rate clock, or it can be powered down. A disabled output is modelled as a constant low together with a separate valid flag that is low.

Top module: `par2ser_x4`

## Requirements
- R1: Each word goes out most significant bit first: bit 3, then bit 2, then bit 1, then bit 0, one bit per serial cycle. Bit 3 is on `sdata_out` in the first serial cycle in which `pclk_out` is high.
- R2: With `dual_edge` low, a word is captured only on a rising edge of `pclk_in`. Any change of `pdata` made at a falling edge never appears on `sdata_out`.
- R3: With `dual_edge` high, a word is captured on every rising edge and on every falling edge of `pclk_in`.
- R4: `pclk_out` is the serial clock divided by 4. It is high for the first 2 serial cycles of each word and low for the last 2. It rises on the cycle in which a new word starts.
- R5: With `lb_pd_n` low, `lb_out` and `lb_valid` are both low, whatever the level of `lb_en`.
- R6: With `lb_pd_n` high, `lb_valid` is high. `lb_out` then follows `sdata_out` when `lb_en` is high and follows `pclk_out` when `lb_en` is low.
- R7: `sclk_oe` equals `sclk_en`. `sclk_out` copies the serial clock when enabled and is constant low when disabled, whichever capture mode is selected.
- R8: Words captured one per word period go out back to back, with no idle word between them. When no new word has been captured, the last word is repeated.
- R9: While reset is asserted, `sdata_out` is low and `pclk_out` is high, because the bit counter sits at the start of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pclk_in | input | 1 | Parallel input clock, generated in step with `clk` |
| pdata | input | WORD_W | Parallel data word; bit WORD_W-1 is sent first |
| dual_edge | input | 1 | 0: capture on rising edge only; 1: capture on both edges |
| sclk_en | input | 1 | Enables the serial clock copy |
| lb_pd_n | input | 1 | Loopback power-down, active low |
| lb_en | input | 1 | Loopback source: 1 = serial data, 0 = word-rate clock |
| sdata_out | output | 1 | Serial data |
| sclk_out | output | 1 | Gated copy of the serial clock |
| sclk_oe | output | 1 | Valid flag for `sclk_out` |
| pclk_out | output | 1 | Word-rate clock, serial clock divided by WORD_W |
| lb_out | output | 1 | Loopback output |
| lb_valid | output | 1 | Valid flag for `lb_out` |

## Verification
The assertions rely on a few properties of the inputs. `pclk_in` changes only between edges of the serial clock and is low while reset is held. It yields exactly one capture per word period, and `dual_edge` changes only while `pclk_in` is steady. The bench drives every edge of `pclk_in` and every change of `pdata` from falling edges of the serial clock. It spaces words exactly four serial cycles apart in both capture modes and returns `pclk_in` low between streams. Each stream starts with a word that differs from the word being repeated, so the scoreboard can tell idle repeats from stream words.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;

  typedef enum logic [1:0] {
    LB_OFF   = 2'd0,
    LB_DATA  = 2'd1,
    LB_CLOCK = 2'd2
  } lb_sel_e;

  function automatic lb_sel_e lb_decode(input logic pd_n, input logic en);
    if (!pd_n)   return LB_OFF;
    else if (en) return LB_DATA;
    else         return LB_CLOCK;
  endfunction

endpackage

// File: rtl/par2ser_rst_sync.sv
module par2ser_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/par2ser_capture.sv
module par2ser_capture #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_in,
  input  logic              dual_edge,
  input  logic [WORD_W-1:0] pdata,
  output logic              cap_stb,
  output logic [WORD_W-1:0] hold_word
);
  logic              prev_q;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              rise, fall;

  always_comb begin
    rise    = pclk_in & ~prev_q;
    fall    = ~pclk_in & prev_q;
    cap_stb = rise | (dual_edge & fall);
    hold_d  = cap_stb ? pdata : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= pclk_in;
      if (cap_stb) hold_q <= hold_d;
    end
  end

  assign hold_word = hold_q;
endmodule

// File: rtl/par2ser_shifter.sv
module par2ser_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] hold_word,
  output logic              load_stb,
  output logic              sdata_out,
  output logic              pclk_out
);
  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    load_stb = (cnt_q == LAST);
    cnt_d    = load_stb ? '0 : cnt_q + 1'b1;
    sh_d     = load_stb ? hold_word : {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign sdata_out = sh_q[WORD_W-1];
  assign pclk_out  = (cnt_q < HALF);
endmodule

// File: rtl/par2ser_lb_mux.sv
module par2ser_lb_mux
  import par2ser_pkg::*;
(
  input  logic lb_pd_n,
  input  logic lb_en,
  input  logic sdata,
  input  logic wclk,
  output logic lb_out,
  output logic lb_valid
);
  lb_sel_e sel;

  always_comb begin
    sel = lb_decode(lb_pd_n, lb_en);
    case (sel)
      LB_DATA:  begin lb_out = sdata; lb_valid = 1'b1; end
      LB_CLOCK: begin lb_out = wclk;  lb_valid = 1'b1; end
      default:  begin lb_out = 1'b0;  lb_valid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/par2ser_x4.sv
module par2ser_x4 #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              pclk_in,
  input  logic [WORD_W-1:0] pdata,
  input  logic              dual_edge,
  input  logic              sclk_en,
  input  logic              lb_pd_n,
  input  logic              lb_en,
  output logic              sdata_out,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              pclk_out,
  output logic              lb_out,
  output logic              lb_valid
);
  logic              rst_n;
  logic              cap_stb;
  logic              load_stb;
  logic [WORD_W-1:0] hold_word;

  par2ser_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  par2ser_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_in   (pclk_in),
    .dual_edge (dual_edge),
    .pdata     (pdata),
    .cap_stb   (cap_stb),
    .hold_word (hold_word)
  );

  par2ser_shifter #(.WORD_W(WORD_W)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_word (hold_word),
    .load_stb  (load_stb),
    .sdata_out (sdata_out),
    .pclk_out  (pclk_out)
  );

  par2ser_lb_mux u_lb (
    .lb_pd_n  (lb_pd_n),
    .lb_en    (lb_en),
    .sdata    (sdata_out),
    .wclk     (pclk_out),
    .lb_out   (lb_out),
    .lb_valid (lb_valid)
  );

  assign sclk_oe  = sclk_en;
  assign sclk_out = clk & sclk_en;
endmodule

// File: rtl/par2ser_x4_chk.sv
module par2ser_x4_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pclk_in,
  input logic              dual_edge,
  input logic              cap_stb,
  input logic              load_stb,
  input logic [WORD_W-1:0] hold_word,
  input logic              sdata_out,
  input logic              pclk_out,
  input logic              lb_pd_n,
  input logic              lb_en,
  input logic              lb_out,
  input logic              lb_valid
);

  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (sdata_out == $past(hold_word[WORD_W-1])));

  a_r2_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_edge && cap_stb) |-> $rose(pclk_in));

  a_r3_both_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_edge && (pclk_in != $past(pclk_in))) |-> cap_stb);

  a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_out) |=> !pclk_out);

  a_r4_rise_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_out) |-> $past(load_stb));

  a_r5_lb_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_pd_n |-> (!lb_out && !lb_valid));

  a_r6_lb_data: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_pd_n && lb_en) |-> (lb_valid && (lb_out == sdata_out)));

  a_r6_lb_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_pd_n && !lb_en) |-> (lb_valid && (lb_out == pclk_out)));

  a_r8_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

endmodule

bind par2ser_x4 par2ser_x4_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pclk_in   (pclk_in),
  .dual_edge (dual_edge),
  .cap_stb   (cap_stb),
  .load_stb  (load_stb),
  .hold_word (hold_word),
  .sdata_out (sdata_out),
  .pclk_out  (pclk_out),
  .lb_pd_n   (lb_pd_n),
  .lb_en     (lb_en),
  .lb_out    (lb_out),
  .lb_valid  (lb_valid)
);

// File: tb/sim_par2ser_x4.sv
`timescale 1ns/1ps
module sim_par2ser_x4;
  localparam int W = 4;

  logic clk = 1'b0;
  logic arst_n, pclk_in, dual_edge, sclk_en, lb_pd_n, lb_en;
  logic [W-1:0] pdata;
  logic sdata_out, sclk_out, sclk_oe, pclk_out, lb_out, lb_valid;

  always #5 clk = ~clk;

  par2ser_x4 #(.WORD_W(W)) u0 (
    .clk(clk), .arst_n(arst_n), .pclk_in(pclk_in), .pdata(pdata),
    .dual_edge(dual_edge), .sclk_en(sclk_en), .lb_pd_n(lb_pd_n), .lb_en(lb_en),
    .sdata_out(sdata_out), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .pclk_out(pclk_out), .lb_out(lb_out), .lb_valid(lb_valid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mon_go = 0;
  string cur_req = "R1 R8";
  logic [W-1:0] expq[$];
  logic [W-1:0] last_w = '0;
  bit in_stream = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: rebuild words from the serial stream
  function automatic void judge(input logic [W-1:0] w);
    checks++;
    if (expq.size() > 0 && w == expq[0]) begin
      void'(expq.pop_front());
      last_w = w;
      in_stream = (expq.size() > 0);
    end else if (!in_stream && w == last_w) begin
      // idle repeat of the last word (R8)
    end else begin
      fails++;
      $display("FAIL %s word got=%0h exp=%0h", cur_req, w,
               (expq.size() > 0) ? expq[0] : last_w);
    end
  endfunction

  initial begin : monitor
    logic [W-1:0] acc;
    int nb;
    logic prev_p;
    acc = '0; nb = 0; prev_p = 1'b1;
    wait (mon_go);
    forever begin
      @(negedge clk);
      #1;
      if (pclk_out && !prev_p) begin
        acc = W'(sdata_out);
        nb = 1;
      end else if (nb > 0) begin
        acc = {acc[W-2:0], sdata_out};
        nb++;
      end
      if (nb == W) begin
        judge(acc);
        nb = 0;
      end
      prev_p = pclk_out;
    end
  end

  // drivers push the expected word as they present it
  task automatic stream_full(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] w;
      w = W'((base + 5 * k) & 15);
      @(negedge clk);
      pdata = w; pclk_in = 1'b1; expq.push_back(w);
      @(negedge clk);
      @(negedge clk);
      pclk_in = 1'b0; pdata = ~w;   // falling-edge data must be ignored (R2)
      @(negedge clk);
    end
  endtask

  task automatic stream_half(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] w;
      w = W'((base + 5 * k) & 15);
      @(negedge clk);
      pdata = w; pclk_in = ~pclk_in; expq.push_back(w);
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    pclk_in = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (expq.size() > 0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk({cur_req, " R8 drain"}, expq.size(), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic pclk_check();
    int highs, rises;
    logic pv;
    highs = 0; rises = 0;
    @(negedge clk); #1; pv = pclk_out;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1;
      if (pclk_out) highs++;
      if (pclk_out && !pv) rises++;
      pv = pclk_out;
    end
    chk("R4 high cycles", highs, 8);
    chk("R4 rises", rises, 4);
  endtask

  task automatic lb_check(input logic pd, input logic en, input string req);
    int bad;
    bad = 0;
    @(negedge clk);
    lb_pd_n = pd; lb_en = en;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1;
      if (!pd) begin
        if (lb_out !== 1'b0 || lb_valid !== 1'b0) bad++;
      end else if (en) begin
        if (lb_out !== sdata_out || lb_valid !== 1'b1) bad++;
      end else begin
        if (lb_out !== pclk_out || lb_valid !== 1'b1) bad++;
      end
    end
    chk(req, bad, 0);
  endtask

  task automatic sclk_check(input logic en);
    logic hi, lo;
    @(negedge clk);
    sclk_en = en;
    @(posedge clk); #1; hi = sclk_out;
    @(negedge clk); #1; lo = sclk_out;
    chk("R7 oe", sclk_oe, en);
    chk("R7 high phase", hi, en);
    chk("R7 low phase", lo, 1'b0);
  endtask

  initial begin : watchdog
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    report();
  end

  initial begin : main
    arst_n = 1'b0; pclk_in = 1'b0; pdata = '0; dual_edge = 1'b0;
    sclk_en = 1'b0; lb_pd_n = 1'b1; lb_en = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 sdata in reset", sdata_out, 0);
    chk("R9 pclk_out in reset", pclk_out, 1);
    chk("R9 lb shows pclk in reset", lb_out, 1);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_go = 1;
    pclk_check();

    cur_req = "R1 R2 R8";
    stream_full(1, 12);
    drain();
    lb_check(1'b1, 1'b1, "R6 data");
    lb_check(1'b1, 1'b0, "R6 clock");
    sclk_check(1'b1);
    sclk_check(1'b0);

    @(negedge clk);
    dual_edge = 1'b1;
    cur_req = "R1 R3 R8";
    stream_half(3, 12);
    drain();
    sclk_check(1'b1);
    sclk_check(1'b0);
    pclk_check();

    @(negedge clk);
    dual_edge = 1'b0;
    cur_req = "R1 R2 R8";
    stream_full(6, 12);
    drain();
    lb_check(1'b0, 1'b1, "R5 off en high");
    lb_check(1'b0, 1'b0, "R5 off en low");

    @(negedge clk);
    dual_edge = 1'b1;
    cur_req = "R1 R3 R8";
    stream_half(9, 12);
    drain();
    lb_check(1'b1, 1'b1, "R6 data after off");

    report();
  end
endmodule